// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block gives a small core memory protection and address translation without a paged MMU. The 32-bit virtual space is cut into eight fixed regions of 512 MB. The top three address bits pick the region. Every region holds a 3-bit physical region base and a 4-bit attribute code. The attribute code is decoded through an irregular rule into read, write and execute rights.

Two independent tables live in the block. One serves instruction fetches and one serves loads and stores. Each lookup presents a virtual address and an access kind. One cycle later the block returns:
- the translated physical address,
- the rights mask of the region it consulted,
- a cause code, which is zero on success or names the prohibited access.

A write port updates one entry of either table at a time.

Top module: `region_xlate_unit`

## Requirements
- R1: The region used for a lookup is selected by virtual address bits [31:29], giving eight regions of 512 MB.
- R2: Read and write rights are both granted when the attribute is below 6 and not equal to 3, or when it equals 14. Otherwise neither is granted.
- R3: Execute right is granted exactly when the attribute lies in the range 1 to 5 inclusive.
- R4: An execute request (`req_kind` = 2) consults the instruction table. A read (`req_kind` = 0), a write (`req_kind` = 1) or a reserved request (`req_kind` = 3) consults the data table.
- R5: `rsp_cause` is 0 when the access is granted. On denial it is 1 for an execute, 2 for a read and 3 for a write. A reserved request (`req_kind` = 3) is always denied with cause 3.
- R6: On a granted access, `rsp_paddr` is the region's 3-bit physical base placed in bits [31:29], ORed with virtual address bits [28:0]. On a denied access, `rsp_paddr` is 0.
- R7: After reset, region i of both tables has physical base i and attribute 2. Every region therefore maps one-to-one with read and write allowed and execute denied.
- R8: A table write with `wr_en` = 1 takes effect at the next clock edge. `wr_itab` = 1 selects the instruction table and 0 selects the data table. A lookup in the same cycle as the write still sees the old entry.
- R9: The response is registered. `rsp_valid` is high exactly one cycle after `req_valid`. While `rsp_valid` is low, `rsp_paddr`, `rsp_rights` and `rsp_cause` are 0.
- R10: `rsp_rights` reports the decoded rights of the consulted region: bit 0 read, bit 1 write, bit 2 execute. This holds whether or not the access was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_vaddr | input | 32 | Virtual address |
| wr_en | input | 1 | Table entry write strobe |
| wr_itab | input | 1 | 1 writes the instruction table, 0 the data table |
| wr_idx | input | 3 | Region entry to write |
| wr_pbase | input | 3 | New physical region base |
| wr_attr | input | 4 | New attribute code |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, 0 on denial |
| rsp_rights | output | 3 | Rights of the consulted region {execute, write, read} |
| rsp_cause | output | 2 | 0 granted, 1 fetch prohibited, 2 load prohibited, 3 store prohibited |

## Verification
The hardest case to reach from the ports is a write and a lookup that hit the same entry in the same cycle. The lookup must return the old entry, and the very next lookup must return the new one. The stimulus reaches this case in two ways:
- Directed steps rewrite a region and read it back in the same cycle and in the following cycle.
- A long randomized run issues frequent writes to both tables and keeps the writes colliding with lookups.

Directed steps also give the two tables conflicting attributes for one region, which shows that each access kind consults the correct table.

// File: rtl/region_pkg.sv
package region_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FETCH = 2'd1,
        CAUSE_LOAD  = 2'd2,
        CAUSE_STORE = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    localparam int TAB_INSTR = 0;
    localparam int TAB_DATA  = 1;
    localparam int NUM_TABS  = 2;

endpackage

// File: rtl/region_attr_decode.sv
module region_attr_decode
    import region_pkg::*;
#(
    parameter int ATTR_W = 4
) (
    input  logic [ATTR_W-1:0] attr,
    output rights_t           rights
);

    localparam int RW_LIMIT = 6;
    localparam int RW_HOLE  = 3;
    localparam int RW_EXTRA = 14;
    localparam int X_LOW    = 1;
    localparam int X_HIGH   = 5;

    always_comb begin
        logic rw_ok;
        rw_ok = ((int'(attr) < RW_LIMIT) && (int'(attr) != RW_HOLE))
              || (int'(attr) == RW_EXTRA);
        rights.r = rw_ok;
        rights.w = rw_ok;
        rights.x = (int'(attr) >= X_LOW) && (int'(attr) <= X_HIGH);
    end

    always_comb begin
        if (rights.x && int'(attr) != RW_HOLE) begin
            a_r2_exec_implies_rw: assert (rights.r && rights.w);
        end
    end

endmodule

// File: rtl/region_table.sv
module region_table #(
    parameter int IDX_W      = 3,
    parameter int ATTR_W     = 4,
    parameter int RESET_ATTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  rd_base,
    output logic [ATTR_W-1:0] rd_attr
);

    localparam int NUM_ENT = 1 << IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0]  base;
        logic [ATTR_W-1:0] attr;
    } entry_t;

    entry_t ent_d [NUM_ENT];
    entry_t ent_q [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx].base = wr_base;
            ent_d[wr_idx].attr = wr_attr;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!rst_n) begin
                ent_q[i].base <= IDX_W'(i);
                ent_q[i].attr <= ATTR_W'(RESET_ATTR);
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rd_base = ent_q[rd_idx].base;
    assign rd_attr = ent_q[rd_idx].attr;

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(wr_idx)].base == $past(wr_base))
               && (ent_q[$past(wr_idx)].attr == $past(wr_attr)));

    a_r8_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_idx == $past(rd_idx) && $past(rst_n) && !$past(wr_en))
            |-> $stable(rd_attr));

endmodule

// File: rtl/region_xlate_unit.sv
module region_xlate_unit
    import region_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 3,
    parameter int ATTR_W     = 4,
    parameter int RESET_ATTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              wr_en,
    input  logic              wr_itab,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_pbase,
    input  logic [ATTR_W-1:0] wr_attr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_rights,
    output logic [1:0]        rsp_cause
);

    localparam int OFFS_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] paddr;
        rights_t           rights;
        fault_cause_e      cause;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0]  region_idx;
    logic [IDX_W-1:0]  tab_base   [NUM_TABS];
    logic [ATTR_W-1:0] tab_attr   [NUM_TABS];
    rights_t           tab_rights [NUM_TABS];

    assign region_idx = req_vaddr[ADDR_W-1 -: IDX_W];

    for (genvar t = 0; t < NUM_TABS; t++) begin : g_tab
        logic tab_wr;
        assign tab_wr = wr_en && (wr_itab == (t == TAB_INSTR));

        region_table #(
            .IDX_W     (IDX_W),
            .ATTR_W    (ATTR_W),
            .RESET_ATTR(RESET_ATTR)
        ) i_table (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tab_wr),
            .wr_idx  (wr_idx),
            .wr_base (wr_pbase),
            .wr_attr (wr_attr),
            .rd_idx  (region_idx),
            .rd_base (tab_base[t]),
            .rd_attr (tab_attr[t])
        );

        region_attr_decode #(
            .ATTR_W(ATTR_W)
        ) i_decode (
            .attr  (tab_attr[t]),
            .rights(tab_rights[t])
        );
    end

    always_comb begin
        acc_kind_e     kind;
        int            sel;
        logic          granted;
        fault_cause_e  deny_cause;

        kind = acc_kind_e'(req_kind);
        sel  = (kind == ACC_EXEC) ? TAB_INSTR : TAB_DATA;

        unique case (kind)
            ACC_READ:  begin granted = tab_rights[sel].r; deny_cause = CAUSE_LOAD;  end
            ACC_WRITE: begin granted = tab_rights[sel].w; deny_cause = CAUSE_STORE; end
            ACC_EXEC:  begin granted = tab_rights[sel].x; deny_cause = CAUSE_FETCH; end
            default:   begin granted = 1'b0;              deny_cause = CAUSE_STORE; end
        endcase

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.rights = tab_rights[sel];
            if (granted) begin
                rsp_d.paddr = {tab_base[sel], req_vaddr[OFFS_W-1:0]};
                rsp_d.cause = CAUSE_NONE;
            end else begin
                rsp_d.cause = deny_cause;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_rights = rsp_q.rights;
    assign rsp_cause  = rsp_q.cause;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cause == 2'd0 && rsp_paddr == '0 && rsp_rights == 3'd0));

    a_r6_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 2'd0) |-> rsp_paddr == '0);

    a_r5_exec_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (rsp_cause == 2'd0 || rsp_cause == 2'd1));

    a_r3_exec_needs_right: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> ((rsp_cause == 2'd0) == rsp_rights[2]));

    a_r5_rsvd_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> rsp_cause == 2'd3);

endmodule

// File: tb/test_region_xlate_unit.sv
`timescale 1ns/1ps
module test_region_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_vaddr = '0;
    logic        wr_en = 1'b0;
    logic        wr_itab = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_pbase = '0;
    logic [3:0]  wr_attr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_rights;
    logic [1:0]  rsp_cause;

    always #4 clk = ~clk;

    region_xlate_unit i_region_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_vaddr(req_vaddr),
        .wr_en(wr_en), .wr_itab(wr_itab), .wr_idx(wr_idx),
        .wr_pbase(wr_pbase), .wr_attr(wr_attr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_rights(rsp_rights), .rsp_cause(rsp_cause)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state: index 0 instruction table, 1 data table
    int m_base [2][8];
    int m_attr [2][8];

    bit          have_exp = 0;
    string       exp_tag;
    bit          e_valid;
    logic [31:0] e_paddr;
    logic [2:0]  e_rights;
    logic [1:0]  e_cause;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] rights_of(input int a);
        bit rw, x;
        rw = (a < 6 && a != 3) || a == 14;   // R2
        x  = (a >= 1 && a <= 5);             // R3
        return {x, rw, rw};
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++) begin
                m_base[t][i] = i;   // R7
                m_attr[t][i] = 2;
            end
    endtask

    task automatic compare_pending();
        if (have_exp) begin
            check({exp_tag, " R9 valid"},  32'(rsp_valid),  32'(e_valid));
            check({exp_tag, " R5 cause"},  32'(rsp_cause),  32'(e_cause));
            check({exp_tag, " R6 paddr"},  rsp_paddr,       e_paddr);
            check({exp_tag, " R10 rights"}, 32'(rsp_rights), 32'(e_rights));
        end
    endtask

    task automatic step(input bit v, input int k, input logic [31:0] a,
                        input bit we, input bit wi, input int wx, input int wb,
                        input int wa, input string tag);
        int tab, idx;
        bit ok;
        @(negedge clk);
        compare_pending();
        req_valid = v; req_kind = 2'(k); req_vaddr = a;
        wr_en = we; wr_itab = wi; wr_idx = 3'(wx); wr_pbase = 3'(wb); wr_attr = 4'(wa);
        // expected response from state before this cycle's write (R8)
        tab = (k == 2) ? 0 : 1;              // R4
        idx = int'(a[31:29]);                // R1
        e_valid = v; e_paddr = '0; e_rights = '0; e_cause = '0;
        if (v) begin
            e_rights = rights_of(m_attr[tab][idx]);
            case (k)
                0: ok = e_rights[0];
                1: ok = e_rights[1];
                2: ok = e_rights[2];
                default: ok = 0;
            endcase
            if (ok) e_paddr = {3'(m_base[tab][idx]), a[28:0]};
            else    e_cause = (k == 2) ? 2'd1 : (k == 0) ? 2'd2 : 2'd3;
        end
        have_exp = 1;
        exp_tag  = tag;
        if (we) begin
            m_base[wi ? 0 : 1][wx] = wb;
            m_attr[wi ? 0 : 1][wx] = wa;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // reset state: outputs quiet
        check("R9 reset valid",  32'(rsp_valid),  0);
        check("R9 reset cause",  32'(rsp_cause),  0);
        check("R9 reset paddr",  rsp_paddr,       0);
        check("R9 reset rights", 32'(rsp_rights), 0);
        rst_n = 1'b1;

        // R7/R1: identity map after reset, every region and kind
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 4; k++)
                step(1, k, {3'(r), 29'h0ABC_1234 ^ 29'(r * 77)}, 0, 0, 0, 0, 0, "R7 R1 reset map");

        // R8: same-cycle write sees old entry, next lookup sees new one
        step(1, 0, 32'h4000_0010, 1, 0, 2, 6, 15, "R8 same cycle old");
        step(1, 0, 32'h4000_0010, 0, 0, 0, 0, 0,  "R8 next cycle new");
        step(1, 1, 32'h4000_0020, 1, 0, 2, 6, 14, "R8 rewrite");
        step(1, 1, 32'h4000_0020, 0, 0, 0, 0, 0,  "R8 translated write");

        // R4: conflicting tables for region 5
        step(0, 0, 0, 1, 1, 5, 1, 4,  "R4 load itab");
        step(0, 0, 0, 1, 0, 5, 3, 12, "R4 load dtab");
        step(1, 2, 32'hA123_4567, 0, 0, 0, 0, 0, "R4 exec uses itab");
        step(1, 0, 32'hA123_4567, 0, 0, 0, 0, 0, "R4 read uses dtab");
        step(1, 3, 32'hA123_4567, 0, 0, 0, 0, 0, "R5 reserved kind");

        // R2/R3: sweep all attribute codes through region 3 of both tables
        for (int at = 0; at < 16; at++) begin
            step(0, 0, 0, 1, 1, 3, 7 - (at % 8), at, "R3 attr set");
            step(0, 0, 0, 1, 0, 3, at % 8, at, "R2 attr set");
            for (int k = 0; k < 4; k++)
                step(1, k, 32'h7FFF_FFF0 - 32'(at), 0, 0, 0, 0, 0, "R2 R3 attr sweep");
        end

        // randomized traffic with frequent colliding writes
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] va;
            int wx;
            va = $urandom;
            wx = (($urandom % 2) == 0) ? int'(va[31:29]) : int'($urandom % 8);
            step(($urandom % 4) != 0, int'($urandom % 4), va,
                 ($urandom % 3) == 0, ($urandom % 2) == 1, wx,
                 int'($urandom % 8), int'($urandom % 16), "R8 random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9 drain");
        @(negedge clk);
        compare_pending();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule